// File: doc/BRIEF.md
# Serial ADC Interface Emulator

This block is a digital stand-in for the serial output side of a two-channel 12-bit converter. It is used in benches and on prototypes to exercise host controllers. It watches an active-low chip select and a serial clock, both sampled in the system clock domain. When chip select falls, it chooses between two conversion clocking schemes, captures a supplied 12-bit sample and channel bit at the scheme's sampling instant, and then presents a 16-bit frame one bit at a time on a data output. The output enable is low whenever chip select is high.

In the self-timed scheme, selected when the serial clock is high as chip select falls, the block captures on the first serial clock fall. It then holds the data line low for a fixed number of system clocks that stand in for the conversion, and raises it as the end-of-conversion flag. In the host-timed scheme, selected when the serial clock is low as chip select falls, the capture happens on the second serial clock fall and the host clock paces the whole frame. The frame is three ones, the channel bit and then the data from the most significant bit down; zeros follow after the frame. A parameter forces the channel bit to zero for the single-channel variant.

Top module: `sadc_if_model`

## Requirements
- R1: After reset, with chip select held high, `dout_oe_o` is 0 and `dout_o` is 0.
- R2: Whenever `cs_n_i` is 1 at a rising `clk` edge, `dout_oe_o` is 0 after that edge; a frame broken off this way does not resume, and only a new falling edge of `cs_n_i` starts a new frame from its first bit.
- R3: The level of `sclk_i` seen in the same `clk` cycle as the falling edge of `cs_n_i` picks the scheme: 1 selects self-timed, 0 selects host-timed; `dout_oe_o` is 1 after that edge.
- R4: Self-timed: `dout_o` is 0 after the chip-select fall. The first `sclk_i` fall captures `sample_i` and `chan_i`. `dout_o` then stays 0 for CONV_CLKS-1 clocks and is 1 from the CONV_CLKS-th rising edge after the capture edge, where CONV_CLKS = (CLK_HZ/OSC_HZ)*SAR_STEPS (325 with the defaults).
- R5: Self-timed readout: with the end-of-conversion 1 as frame bit 0, each later `sclk_i` fall advances `dout_o` to the next frame bit.
- R6: Host-timed: frame bit k is 1 for k = 0..2, the channel bit for k = 3, sample bit 15-k for k = 4..15, and 0 for k >= 16. `dout_o` shows bit 0 after the chip-select fall and bit k after the k-th `sclk_i` fall. The capture takes place on the second fall.
- R7: Changes on `sample_i` and `chan_i` after the capture edge do not alter the frame being shifted out.
- R8: `dout_o` changes only in response to an `sclk_i` fall, the chip-select edges or the end of conversion; an `sclk_i` rise leaves it unchanged.
- R9: With SINGLE_CH = 1 the channel bit in the frame is 0 whatever `chan_i` is.
- R10: `sclk_i` edges while the conversion is running are ignored and do not move the end-of-conversion point.
- R11: Every input change is reflected on the outputs after the first rising `clk` edge that sees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Chip select, active low, synchronous to clk |
| sclk_i | input | 1 | Serial clock from host, synchronous to clk |
| sample_i | input | DATA_W | Sample value to report |
| chan_i | input | 1 | Channel identity to report |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Output enable for the data line (0 means high impedance) |

## Verification
A wrong scheme decision at the chip-select edge is visible after one clock, because the data line starts at 1 instead of 0 or the reverse. A bit index that slips or fails to saturate shows up within a few serial clock falls as a channel bit or data bit in the wrong place, or as non-zero trailing bits after bit 15. A conversion counter that is off by one moves the end-of-conversion rise by one clock, and the bench checks the clock before and the clock of the expected rise. Capture at the wrong instant shows up once the bench changes the sample input after the expected capture edge.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CONV  = 2'd2,
    ST_SHIFT = 2'd3
  } sadc_state_e;

  typedef enum logic {
    MD_EXT = 1'b0,
    MD_INT = 1'b1
  } sadc_mode_e;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // R11
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sadc_conv_timer.sv
module sadc_conv_timer #(
  parameter int unsigned CONV_CLKS = 325
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clear_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CLKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign done_o = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (clear_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CONV_CLKS - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // R4
  conv_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !clear_i && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4
  conv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i) |=> (busy_q && !done_o));
endmodule

// File: rtl/sadc_frame_sel.sv
module sadc_frame_sel #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              chid_i,
  output logic              bit_o
);
  localparam int unsigned LEAD_ONES = 3;
  localparam int unsigned FRAME_LEN = DATA_W + LEAD_ONES + 1;

  always_comb begin
    int k;
    k = int'(idx_i);
    if (k < LEAD_ONES)        bit_o = 1'b1;
    else if (k == LEAD_ONES)  bit_o = chid_i;
    else if (k < FRAME_LEN)   bit_o = data_i[FRAME_LEN-1-k];
    else                      bit_o = 1'b0;
  end
endmodule

// File: rtl/sadc_if_model.sv
module sadc_if_model
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned OSC_HZ    = 2_000_000,
  parameter int unsigned SAR_STEPS = 13,
  parameter bit          SINGLE_CH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              chan_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  localparam int unsigned CONV_CLKS = (CLK_HZ / OSC_HZ) * SAR_STEPS;
  localparam int unsigned FRAME_LEN = DATA_W + 4;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic cs_fall, sclk_fall, tmr_start, tmr_done, next_bit, chid_in;

  sadc_edge_det #(.IDLE_LVL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(cs_n_i), .fall_o(cs_fall));

  sadc_edge_det #(.IDLE_LVL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(sclk_i), .fall_o(sclk_fall));

  sadc_conv_timer #(.CONV_CLKS(CONV_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start_i(tmr_start),
    .clear_i(cs_n_i), .done_o(tmr_done));

  generate
    if (SINGLE_CH) begin : g_one_ch
      assign chid_in = 1'b0;
    end else begin : g_two_ch
      assign chid_in = chan_i;
    end
  endgenerate

  sadc_state_e         state_q, state_d;
  sadc_mode_e          mode_q, mode_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [DATA_W-1:0]   data_q, data_d;
  logic                chid_q, chid_d;
  logic                dout_q, dout_d;

  sadc_frame_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_frame (
    .idx_i(idx_d), .data_i(data_d), .chid_i(chid_d), .bit_o(next_bit));

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    idx_d     = idx_q;
    data_d    = data_q;
    chid_d    = chid_q;
    dout_d    = dout_q;
    tmr_start = 1'b0;
    if (cs_n_i) begin
      state_d = ST_IDLE;
      dout_d  = 1'b0;
    end else if (cs_fall) begin
      idx_d = '0;
      if (sclk_i) begin
        mode_d  = MD_INT;
        state_d = ST_WAIT;
        dout_d  = 1'b0;
      end else begin
        mode_d  = MD_EXT;
        state_d = ST_SHIFT;
        dout_d  = 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_WAIT: if (sclk_fall) begin
          data_d    = sample_i;
          chid_d    = chid_in;
          tmr_start = 1'b1;
          state_d   = ST_CONV;
        end
        ST_CONV: if (tmr_done) begin
          state_d = ST_SHIFT;
          idx_d   = '0;
          dout_d  = 1'b1;
        end
        ST_SHIFT: if (sclk_fall) begin
          if (mode_q == MD_EXT && idx_q == IDX_W'(1)) begin
            data_d = sample_i;
            chid_d = chid_in;
          end
          if (idx_q != IDX_W'(FRAME_LEN)) idx_d = idx_q + 1'b1;
          dout_d = next_bit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MD_EXT;
      idx_q   <= '0;
      data_q  <= '0;
      chid_q  <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      chid_q  <= chid_d;
      dout_q  <= dout_d;
    end
  end

  assign dout_o    = dout_q;
  assign dout_oe_o = (state_q != ST_IDLE);

  // R2
  hiz_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n_i |=> !dout_oe_o);

  // R3
  mode_pick_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_fall && !cs_n_i) |=> (dout_oe_o && (dout_o == (mode_q == MD_EXT))));

  // R6
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_SHIFT && !cs_n_i && sclk_fall && idx_q < IDX_W'(FRAME_LEN))
      |=> (idx_q == $past(idx_q) + 1'b1));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_SHIFT && !cs_n_i && !sclk_fall) |=> $stable(dout_o));

  // R4
  conv_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_CONV) |-> (dout_oe_o && !dout_o));
endmodule

// File: tb/test_sadc_if_model.sv
module test_sadc_if_model;
  localparam int DW   = 12;
  localparam int CONV = 325;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [DW-1:0] sample = '0;
  logic chan = 1'b0;
  logic dout, oe, sc_dout, sc_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sadc_if_model i_sadc_if_model (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .sample_i(sample), .chan_i(chan), .dout_o(dout), .dout_oe_o(oe));

  sadc_if_model #(.SINGLE_CH(1'b1)) i_sadc_if_model_sc (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .sample_i(sample), .chan_i(chan), .dout_o(sc_dout), .dout_oe_o(sc_oe));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic fbit(input int k, input logic [DW-1:0] d, input logic ch);
    logic [DW+3:0] fr;
    fr = {3'b111, ch, d};
    if (k < DW + 4) return fr[DW+3-k];
    return 1'b0;
  endfunction

  task automatic t_reset();
    chk("R1 oe", oe, 1'b0);
    chk("R1 dout", dout, 1'b0);
  endtask

  task automatic t_external(input logic [DW-1:0] d, input logic ch);
    cs_n = 1'b1; sclk = 1'b0; sample = d; chan = ch; step();
    cs_n = 1'b0; step();
    chk("R3 ext oe", oe, 1'b1);
    chk("R6 bit0", dout, 1'b1);
    for (int k = 1; k <= 20; k++) begin
      sclk = 1'b1; step();
      chk("R8 rise hold", dout, fbit(k - 1, d, ch));
      sclk = 1'b0; step();
      if (k == 2) begin sample = ~d; chan = ~ch; end  // R7
      chk("R6 bit", dout, fbit(k, d, ch));
      if (k == 3) chk("R9 single chid", sc_dout, 1'b0);
    end
    cs_n = 1'b1; step();
    chk("R2 hiz", oe, 1'b0);
  endtask

  task automatic t_internal(input logic [DW-1:0] d, input logic ch);
    cs_n = 1'b1; sclk = 1'b1; sample = d; chan = ch; step();
    cs_n = 1'b0; step();
    chk("R3 int oe", oe, 1'b1);
    chk("R4 low at start", dout, 1'b0);
    sclk = 1'b0; step();
    sample = ~d; chan = ~ch;  // R7
    for (int i = 1; i < CONV; i++) begin
      if (i == 10 || i == 30) sclk = 1'b1;   // R10 toggles mid-conversion
      if (i == 20) sclk = 1'b0;
      step();
    end
    chk("R4 R10 still converting", dout, 1'b0);
    step();
    chk("R4 eoc", dout, 1'b1);
    for (int k = 1; k <= 18; k++) begin
      sclk = 1'b0; step();
      chk("R5 R7 bit", dout, fbit(k, d, ch));
      sclk = 1'b1; step();
    end
    cs_n = 1'b1; step();
    chk("R2 hiz after int", oe, 1'b0);
  endtask

  task automatic t_abort(input logic [DW-1:0] d);
    cs_n = 1'b1; sclk = 1'b0; sample = d; chan = 1'b1; step();
    cs_n = 1'b0; step();
    for (int k = 1; k <= 6; k++) begin
      sclk = 1'b1; step(); sclk = 1'b0; step();
    end
    cs_n = 1'b1; step();
    chk("R2 abort hiz", oe, 1'b0);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; step(); sclk = 1'b0; step();
      chk("R2 stays hiz", oe, 1'b0);
    end
    cs_n = 1'b0; step();
    chk("R2 restart bit0", dout, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      sclk = 1'b1; step(); sclk = 1'b0; step();
      chk("R2 R11 fresh frame", dout, fbit(k, d, 1'b1));
    end
    cs_n = 1'b1; step();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_external(12'hA5C, 1'b1);
    t_external(12'h3B1, 1'b0);
    t_internal(12'hC3E, 1'b1);
    t_internal(12'h05A, 1'b0);
    t_abort(12'h9F0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule